// File: doc/BRIEF.md
# Command-Mode Tear-Check Pacer

This block follows the scan position of a command-mode panel and decides when a frame writer may start or keep writing without tearing. A line counter stands in for the panel's read position. It steps forward once per programmed number of clocks, wraps after the last visible line, and is reloaded with a programmed line value on every vertical-sync event. That event comes either from an internal period timer or from an asynchronous frame-sync pin. The pin is resynchronised and only its rising edge is used.

Against this read position the block grants start permission inside a programmed window of lines beginning at a programmed position. It also reports whether the writer's line count is far enough ahead of the read position to continue. The first margin violation in a frame gives a one-cycle stall pulse, and that frame is then left out of the sent-frame count. The block also raises a one-cycle interrupt when the read position reaches a programmed line. It exposes the current read line, the sampled writer line, the sent-frame count and the count of frames the writer reports as completed.

Top module: `te_scan_pacer`

## Requirements
- R1: While `rst_n` is low or `en` is low, every output is 0 one clock edge later and stays 0. Raising `en` starts all counts from 0.
- R2: With `en` high and no sync event, `rd_line` steps up by one on every Nth clock edge, where N is `cfg_line_clks`. A value of 0 acts as 1.
- R3: A step taken while `rd_line` is at or above `cfg_last_line` gives 0 instead of an increment.
- R4: A sync event loads `cfg_load_line` into `rd_line` on the same edge that raises `vsync_pulse`, and it restarts the N-clock step count.
- R5: With `cfg_ext_sync` = 0, a sync event happens every `cfg_frame_clks`+1 clocks, the first one `cfg_frame_clks`+1 edges after `en` rises. `vsync_pulse` is high for one cycle at each.
- R6: With `cfg_ext_sync` = 1, the internal timer is held at zero. A rising edge on `ext_vsync_in`, first seen high at clock edge k, produces the sync event at edge k+2, so `vsync_pulse` is high in the cycle after edge k+2. A held-high level gives only one event.
- R7: `rd_irq` is high for one cycle each time `rd_line` takes a new value, by a step or a load, that equals `cfg_irq_line`.
- R8: `start_ok` is high exactly when `cfg_start_pos` <= `rd_line` < `cfg_start_pos` + `cfg_start_win`. The sum is computed one bit wider and does not wrap.
- R9: `wr_line_seen` is `wr_line` sampled at the last edge. `cont_ok` is high exactly when `wr_line_seen` >= `rd_line` + `cfg_keep_ahead`, computed one bit wider.
- R10: `stall_err` is high for one cycle when `wr_active` was high at the edge and the margin of R9 fails. This happens at most once between sync events. A violation on the edge of a sync event belongs to the new frame.
- R11: `frames_sent` increments on a sync event only if no stall occurred since the previous sync event (or since enable). It changes at no other time.
- R12: `frames_read` increments by one for every edge at which `wr_frame_done` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Block enable; low clears all state |
| cfg_ext_sync | input | 1 | 0: internal timer sync, 1: external pin sync |
| cfg_line_clks | input | CLK_W | Clocks per line (0 treated as 1) |
| cfg_frame_clks | input | PER_W | Internal sync period minus one, in clocks |
| cfg_last_line | input | LINE_W | Last line index (total lines minus one) |
| cfg_load_line | input | LINE_W | Line value loaded at each sync event |
| cfg_irq_line | input | LINE_W | Line that raises the interrupt |
| cfg_start_pos | input | LINE_W | First line of the start window |
| cfg_start_win | input | LINE_W | Start window length in lines |
| cfg_keep_ahead | input | LINE_W | Minimum lead of writer over reader |
| ext_vsync_in | input | 1 | Asynchronous external frame sync |
| wr_line | input | LINE_W | Writer's current line count |
| wr_active | input | 1 | Writer is inside a frame |
| wr_frame_done | input | 1 | Writer finished a frame (one pulse per frame) |
| rd_line | output | LINE_W | Current read line |
| vsync_pulse | output | 1 | One-cycle sync event marker |
| rd_irq | output | 1 | One-cycle read-line interrupt |
| start_ok | output | 1 | Write start permitted |
| cont_ok | output | 1 | Writer margin satisfied |
| stall_err | output | 1 | One-cycle margin violation flag |
| wr_line_seen | output | LINE_W | Sampled writer line |
| frames_sent | output | CNT_W | Frames completed without a stall |
| frames_read | output | CNT_W | Frames reported done by the writer |

## Verification
A sync event and a margin violation can fall on the same edge. The outcome then depends on ordering: the frame being closed is counted by its own earlier history, and the violation opens the flag of the new frame. The bench drives a pseudo-random writer line and activity pattern across short internal periods and external pulses, so such coincidences happen repeatedly. A per-cycle reference model derived from R10 and R11 predicts `stall_err` and `frames_sent`, and a scoreboard compares both each cycle. A load that lands on the interrupt line or on the wrap boundary is judged the same way against R3, R4 and R7.

// File: rtl/te_pacer_pkg.sv
package te_pacer_pkg;

    // Origin of the frame sync event
    typedef enum logic {
        SRC_TIMER = 1'b0,
        SRC_PIN   = 1'b1
    } vs_src_e;

endpackage

// File: rtl/te_sync_edge.sv
// Resynchronises an asynchronous level and reports its rising edge.
module te_sync_edge #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic rise
);
    localparam int DEPTH = STAGES + 1;

    logic [DEPTH-1:0] sh_d, sh_q;

    always_comb begin
        sh_d[0] = async_in;
        for (int i = 1; i < DEPTH; i++) begin
            sh_d[i] = sh_q[i-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= sh_d;
    end

    assign rise = sh_q[STAGES-1] & ~sh_q[STAGES];
endmodule

// File: rtl/te_vsync_src.sv
// Picks the sync event from an internal period timer or the pin edge.
module te_vsync_src
    import te_pacer_pkg::*;
#(
    parameter int PER_W = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             ext_mode,
    input  logic [PER_W-1:0] cfg_period,
    input  logic             pin_rise,
    output logic             vs_evt
);
    vs_src_e          src;
    logic [PER_W-1:0] per_d, per_q;
    logic             tmr_hit;

    always_comb begin
        src     = vs_src_e'(ext_mode);
        tmr_hit = (per_q >= cfg_period);
        if (!en || src == SRC_PIN)  per_d = '0;
        else if (tmr_hit)           per_d = '0;
        else                        per_d = per_q + PER_W'(1);
        if (!en)                    vs_evt = 1'b0;
        else if (src == SRC_PIN)    vs_evt = pin_rise;
        else                        vs_evt = tmr_hit;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) per_q <= '0;
        else        per_q <= per_d;
    end
endmodule

// File: rtl/te_line_tracker.sv
// Read-line counter: steps every N clocks, wraps, reloads on sync.
module te_line_tracker #(
    parameter int LINE_W = 12,
    parameter int CLK_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              vs_evt,
    input  logic [CLK_W-1:0]  cfg_line_clks,
    input  logic [LINE_W-1:0] cfg_last_line,
    input  logic [LINE_W-1:0] cfg_load_line,
    input  logic [LINE_W-1:0] cfg_irq_line,
    output logic [LINE_W-1:0] line_q_o,
    output logic [LINE_W-1:0] line_nxt_o,
    output logic              irq_o,
    output logic              vs_o
);
    typedef struct packed {
        logic [CLK_W-1:0]  cnt;
        logic [LINE_W-1:0] line;
        logic              irq;
        logic              vs;
    } trk_t;

    trk_t             st_d, st_q;
    logic [CLK_W-1:0] last_clk;
    logic             upd;

    always_comb begin
        last_clk = (cfg_line_clks == '0) ? '0 : cfg_line_clks - CLK_W'(1);
        st_d     = st_q;
        upd      = 1'b0;
        if (!en) begin
            st_d = '0;
        end else begin
            if (vs_evt) begin
                st_d.line = cfg_load_line;
                st_d.cnt  = '0;
                upd       = 1'b1;
            end else if (st_q.cnt >= last_clk) begin
                st_d.cnt  = '0;
                st_d.line = (st_q.line >= cfg_last_line) ? '0
                                                         : st_q.line + LINE_W'(1);
                upd       = 1'b1;
            end else begin
                st_d.cnt  = st_q.cnt + CLK_W'(1);
            end
            st_d.irq = upd && (st_d.line == cfg_irq_line);
            st_d.vs  = vs_evt;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign line_q_o   = st_q.line;
    assign line_nxt_o = st_d.line;
    assign irq_o      = st_q.irq;
    assign vs_o       = st_q.vs;
endmodule

// File: rtl/te_write_gate.sv
// Start window, continue margin and per-frame stall tracking.
module te_write_gate #(
    parameter int LINE_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              vs_evt,
    input  logic [LINE_W-1:0] rd_nxt,
    input  logic [LINE_W-1:0] wr_line,
    input  logic              wr_active,
    input  logic [LINE_W-1:0] cfg_start_pos,
    input  logic [LINE_W-1:0] cfg_start_win,
    input  logic [LINE_W-1:0] cfg_keep_ahead,
    output logic              start_ok_o,
    output logic              cont_ok_o,
    output logic              stall_o,
    output logic              viol_o,
    output logic [LINE_W-1:0] wr_line_o
);
    localparam int XW = LINE_W + 1;

    typedef struct packed {
        logic              start_ok;
        logic              cont_ok;
        logic              stall;
        logic              viol;
        logic [LINE_W-1:0] wr_line;
    } gate_t;

    gate_t          st_d, st_q;
    logic [XW-1:0]  rd_x, win_lo, win_hi, need;
    logic           stall_now;

    always_comb begin
        rd_x   = {1'b0, rd_nxt};
        win_lo = {1'b0, cfg_start_pos};
        win_hi = win_lo + {1'b0, cfg_start_win};
        need   = rd_x + {1'b0, cfg_keep_ahead};

        st_d          = '0;
        stall_now     = 1'b0;
        if (en) begin
            st_d.start_ok = (rd_x >= win_lo) && (rd_x < win_hi);
            st_d.cont_ok  = ({1'b0, wr_line} >= need);
            stall_now     = wr_active && !st_d.cont_ok && (vs_evt || !st_q.viol);
            st_d.stall    = stall_now;
            st_d.viol     = vs_evt ? stall_now : (st_q.viol | stall_now);
            st_d.wr_line  = wr_line;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign start_ok_o = st_q.start_ok;
    assign cont_ok_o  = st_q.cont_ok;
    assign stall_o    = st_q.stall;
    assign viol_o     = st_q.viol;
    assign wr_line_o  = st_q.wr_line;
endmodule

// File: rtl/te_scan_pacer.sv
// Top: command-mode tear-check pacer.
module te_scan_pacer #(
    parameter int LINE_W      = 12,
    parameter int CLK_W       = 16,
    parameter int PER_W       = 24,
    parameter int CNT_W       = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              cfg_ext_sync,
    input  logic [CLK_W-1:0]  cfg_line_clks,
    input  logic [PER_W-1:0]  cfg_frame_clks,
    input  logic [LINE_W-1:0] cfg_last_line,
    input  logic [LINE_W-1:0] cfg_load_line,
    input  logic [LINE_W-1:0] cfg_irq_line,
    input  logic [LINE_W-1:0] cfg_start_pos,
    input  logic [LINE_W-1:0] cfg_start_win,
    input  logic [LINE_W-1:0] cfg_keep_ahead,
    input  logic              ext_vsync_in,
    input  logic [LINE_W-1:0] wr_line,
    input  logic              wr_active,
    input  logic              wr_frame_done,
    output logic [LINE_W-1:0] rd_line,
    output logic              vsync_pulse,
    output logic              rd_irq,
    output logic              start_ok,
    output logic              cont_ok,
    output logic              stall_err,
    output logic [LINE_W-1:0] wr_line_seen,
    output logic [CNT_W-1:0]  frames_sent,
    output logic [CNT_W-1:0]  frames_read
);
    typedef struct packed {
        logic [CNT_W-1:0] sent;
        logic [CNT_W-1:0] read;
    } cnt_t;

    logic              pin_rise;
    logic              vs_evt;
    logic [LINE_W-1:0] rd_nxt;
    logic              frame_viol;
    cnt_t              cnt_d, cnt_q;

    te_sync_edge #(.STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (ext_vsync_in),
        .rise     (pin_rise)
    );

    te_vsync_src #(.PER_W(PER_W)) u_vsrc (
        .clk        (clk),
        .rst_n      (rst_n),
        .en         (en),
        .ext_mode   (cfg_ext_sync),
        .cfg_period (cfg_frame_clks),
        .pin_rise   (pin_rise),
        .vs_evt     (vs_evt)
    );

    te_line_tracker #(.LINE_W(LINE_W), .CLK_W(CLK_W)) u_trk (
        .clk           (clk),
        .rst_n         (rst_n),
        .en            (en),
        .vs_evt        (vs_evt),
        .cfg_line_clks (cfg_line_clks),
        .cfg_last_line (cfg_last_line),
        .cfg_load_line (cfg_load_line),
        .cfg_irq_line  (cfg_irq_line),
        .line_q_o      (rd_line),
        .line_nxt_o    (rd_nxt),
        .irq_o         (rd_irq),
        .vs_o          (vsync_pulse)
    );

    te_write_gate #(.LINE_W(LINE_W)) u_gate (
        .clk            (clk),
        .rst_n          (rst_n),
        .en             (en),
        .vs_evt         (vs_evt),
        .rd_nxt         (rd_nxt),
        .wr_line        (wr_line),
        .wr_active      (wr_active),
        .cfg_start_pos  (cfg_start_pos),
        .cfg_start_win  (cfg_start_win),
        .cfg_keep_ahead (cfg_keep_ahead),
        .start_ok_o     (start_ok),
        .cont_ok_o      (cont_ok),
        .stall_o        (stall_err),
        .viol_o         (frame_viol),
        .wr_line_o      (wr_line_seen)
    );

    // Frame counters; a frame with a stall is not counted as sent
    always_comb begin
        cnt_d = cnt_q;
        if (!en) begin
            cnt_d = '0;
        end else begin
            if (vs_evt && !frame_viol) cnt_d.sent = cnt_q.sent + CNT_W'(1);
            if (wr_frame_done)         cnt_d.read = cnt_q.read + CNT_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign frames_sent = cnt_q.sent;
    assign frames_read = cnt_q.read;
endmodule

// File: rtl/te_scan_pacer_chk.sv
module te_scan_pacer_chk #(
    parameter int LINE_W = 12,
    parameter int CNT_W  = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              en,
    input logic [LINE_W-1:0] cfg_last_line,
    input logic [LINE_W-1:0] cfg_load_line,
    input logic [LINE_W-1:0] cfg_irq_line,
    input logic [LINE_W-1:0] cfg_start_pos,
    input logic [LINE_W-1:0] rd_line,
    input logic              vsync_pulse,
    input logic              rd_irq,
    input logic              start_ok,
    input logic              cont_ok,
    input logic              stall_err,
    input logic [CNT_W-1:0]  frames_sent
);
    assert_disabled_clear_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (rd_line == '0 && frames_sent == '0 && !vsync_pulse));

    assert_wrap_to_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (en && $past(en) && !vsync_pulse && rd_line != $past(rd_line)
         && $past(rd_line) >= $past(cfg_last_line)) |-> rd_line == '0);

    assert_sync_loads_R4: assert property (@(posedge clk) disable iff (!rst_n)
        vsync_pulse |-> rd_line == $past(cfg_load_line));

    assert_irq_on_line_R7: assert property (@(posedge clk) disable iff (!rst_n)
        rd_irq |-> rd_line == $past(cfg_irq_line));

    assert_start_floor_R8: assert property (@(posedge clk) disable iff (!rst_n)
        start_ok |-> rd_line >= $past(cfg_start_pos));

    assert_stall_needs_fail_R10: assert property (@(posedge clk) disable iff (!rst_n)
        stall_err |-> !cont_ok);

    assert_sent_only_at_sync_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (en && $past(en) && !vsync_pulse) |-> frames_sent == $past(frames_sent));
endmodule

bind te_scan_pacer te_scan_pacer_chk #(.LINE_W(LINE_W), .CNT_W(CNT_W)) u_chk (.*);

// File: tb/te_scan_pacer_tb.sv
module te_scan_pacer_tb;
    localparam int CLK_PERIOD = 10;
    localparam int LW = 12;
    localparam int CW = 16;
    localparam int PW = 24;
    localparam int NW = 16;

    typedef struct {
        int line; bit vs; bit irq; bit st; bit co; bit stall;
        int wl; int sent; int rd;
    } exp_t;

    logic clk = 0, rst_n = 0, en = 0, cfg_ext_sync = 0;
    logic [CW-1:0] cfg_line_clks = 3;
    logic [PW-1:0] cfg_frame_clks = 39;
    logic [LW-1:0] cfg_last_line = 9, cfg_load_line = 2, cfg_irq_line = 5;
    logic [LW-1:0] cfg_start_pos = 3, cfg_start_win = 4, cfg_keep_ahead = 2;
    logic ext_vsync_in = 0, wr_active = 0, wr_frame_done = 0;
    logic [LW-1:0] wr_line = 0;
    logic [LW-1:0] rd_line, wr_line_seen;
    logic vsync_pulse, rd_irq, start_ok, cont_ok, stall_err;
    logic [NW-1:0] frames_sent, frames_read;

    int checks = 0, fails = 0, cyc = 0;
    bit done = 0;
    exp_t q[$];
    logic [15:0] lfsr = 16'hACE1;

    always #(CLK_PERIOD/2) clk = ~clk;

    te_scan_pacer u_dut (.*);

    task automatic chk(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", tag, act, exp, cyc);
        end
    endtask

    // Reference model: builds the expected outputs after each edge
    int m_cnt = 0, m_line = 0, m_per = 0, m_sent = 0, m_rd = 0;
    bit m_viol = 0, s0 = 0, s1 = 0, s2 = 0;
    always @(posedge clk) begin
        exp_t e;
        bit rise, evt, upd;
        int n1;
        cyc++;
        e = '{default: 0};
        if (!rst_n) begin
            m_cnt = 0; m_line = 0; m_per = 0; m_sent = 0; m_rd = 0;
            m_viol = 0; s0 = 0; s1 = 0; s2 = 0;
        end else begin
            rise = s1 && !s2;
            s2 = s1; s1 = s0; s0 = ext_vsync_in;
            evt = 0;
            if (!en || cfg_ext_sync) begin
                m_per = 0;
                evt = en && cfg_ext_sync && rise;
            end else if (m_per >= int'(cfg_frame_clks)) begin
                m_per = 0; evt = 1;
            end else m_per++;
            if (!en) begin
                m_cnt = 0; m_line = 0; m_sent = 0; m_rd = 0; m_viol = 0;
            end else begin
                n1 = (cfg_line_clks == 0) ? 0 : int'(cfg_line_clks) - 1;
                upd = 0;
                if (evt) begin
                    m_line = cfg_load_line; m_cnt = 0; upd = 1;
                end else if (m_cnt >= n1) begin
                    m_cnt = 0; upd = 1;
                    m_line = (m_line >= int'(cfg_last_line)) ? 0 : m_line + 1;
                end else m_cnt++;
                e.line = m_line;
                e.vs   = evt;
                e.irq  = upd && (m_line == int'(cfg_irq_line));
                e.st   = (m_line >= int'(cfg_start_pos)) &&
                         (m_line < int'(cfg_start_pos) + int'(cfg_start_win));
                e.co   = int'(wr_line) >= m_line + int'(cfg_keep_ahead);
                e.stall = wr_active && !e.co && (evt || !m_viol);
                if (evt && !m_viol) m_sent = (m_sent + 1) % 65536;
                m_viol = evt ? e.stall : (m_viol || e.stall);
                if (wr_frame_done) m_rd = (m_rd + 1) % 65536;
                e.wl = wr_line;
                e.sent = m_sent;
                e.rd = m_rd;
            end
        end
        q.push_back(e);
    end

    // Monitor: compares the design against the scoreboard away from the edge
    always @(negedge clk) begin
        exp_t e;
        if (q.size() > 0) begin
            e = q.pop_front();
            chk("R2 R3 R4 rd_line", rd_line, e.line);
            chk("R5 R6 vsync_pulse", vsync_pulse, e.vs);
            chk("R7 rd_irq", rd_irq, e.irq);
            chk("R8 start_ok", start_ok, e.st);
            chk("R9 cont_ok", cont_ok, e.co);
            chk("R9 wr_line_seen", wr_line_seen, e.wl);
            chk("R10 stall_err", stall_err, e.stall);
            chk("R11 frames_sent", frames_sent, e.sent);
            chk("R12 frames_read", frames_read, e.rd);
        end
    end

    // Driver: pseudo-random writer activity, optional external pulse train
    task automatic drive(int n, bit ext_train);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            wr_line       = LW'(lfsr[3:0]);
            wr_active     = lfsr[5] | lfsr[6];
            wr_frame_done = lfsr[9] & lfsr[10] & lfsr[11];
            if (ext_train) ext_vsync_in = ((i % 23) < 6);
        end
    endtask

    initial begin
        // R1: reset state
        repeat (4) @(negedge clk);
        chk("R1 reset rd_line", rd_line, 0);
        chk("R1 reset frames_sent", frames_sent, 0);
        rst_n = 1;
        drive(3, 0);
        chk("R1 disabled vsync_pulse", vsync_pulse, 0);
        // Internal sync, multi-clock lines
        en = 1;
        drive(260, 0);
        // Wrap before sync, one-clock lines and zero treated as one
        cfg_line_clks = 1; cfg_last_line = 4; cfg_frame_clks = 57;
        cfg_load_line = 4; cfg_irq_line = 4;
        drive(150, 0);
        cfg_line_clks = 0; cfg_keep_ahead = 0; cfg_start_win = 0;
        drive(120, 0);
        // Disable clears, then restart
        en = 0;
        drive(4, 0);
        chk("R1 disabled frames_read", frames_read, 0);
        en = 1; cfg_line_clks = 2; cfg_last_line = 11; cfg_keep_ahead = 3;
        cfg_start_win = 5; cfg_irq_line = 0; cfg_load_line = 1; cfg_frame_clks = 16;
        drive(200, 0);
        // External sync with a directed latency check
        cfg_ext_sync = 1; ext_vsync_in = 0;
        drive(10, 0);
        @(negedge clk); ext_vsync_in = 1;
        @(negedge clk); chk("R6 no pulse after 1 edge", vsync_pulse, 0);
        @(negedge clk); chk("R6 no pulse after 2 edges", vsync_pulse, 0);
        @(negedge clk); chk("R6 pulse after 3 edges", vsync_pulse, 1);
        chk("R4 load on pin sync", rd_line, 1);
        @(negedge clk); chk("R6 held level single pulse", vsync_pulse, 0);
        drive(300, 1);
        ext_vsync_in = 0;
        drive(5, 0);
        done = 1;
        @(negedge clk);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end
endmodule